// File: doc/BRIEF.md
# ADC Result Byte Latch with Coherent Two-Access Read

This block sits between a converter that produces a 10-bit result and an 8-bit register bus. Each completed result is held and shown as two bytes, low and high. An adjust input picks one of two packings. In the right-aligned packing, the whole low byte carries the low part of the result. In the left-aligned packing, the high byte carries the eight most significant bits, so a reader that needs only 8 bits can read the high byte alone.

A result read in two bus accesses has to stay coherent. A read of the low byte therefore freezes both bytes. The freeze ends with the next read of the high byte. If a conversion finishes while the bytes are frozen, its result is thrown away. A one-cycle lost indication marks the discard, and the completion flag still sets. The flag is cleared by writing one to its clear input.

Top module: `adc_result_latch`

## Requirements
- R1: After a synchronous reset, both bytes read 0x00, the interrupt flag is 0 and the registers are unlocked.
- R2: Right-aligned packing (`left_adj`=0): `data_lo` = result[7:0] and `data_hi` = {6'b0, result[9:8]}.
- R3: Left-aligned packing (`left_adj`=1): `data_hi` = result[9:2] and `data_lo` = {result[1:0], 6'b0}.
- R4: A change of `left_adj` repacks the held result in the same cycle, with no new conversion needed.
- R5: A cycle with `rd_lo`=1 locks the registers from the next cycle onward. A completion (`res_valid`=1) while locked leaves both bytes unchanged, and `lost` is 1 in that cycle.
- R6: A cycle with `rd_hi`=1 (and `rd_lo`=0) unlocks the registers from the next cycle. A completion in the same cycle as that unlocking read is still discarded.
- R7: A `rd_hi` read while unlocked does not lock the registers. A later completion is accepted.
- R8: The interrupt flag is 1 in the cycle after every completion, including a discarded one.
- R9: `flag_clr`=1 clears the flag in the next cycle. If `res_valid` is also 1 in that cycle, the set wins.
- R10: A completion in the same cycle as a locking `rd_lo` is accepted, because the lock starts only in the next cycle. If `rd_lo` and `rd_hi` are both 1 in a cycle, the registers end up locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_data | input | 10 | Conversion result |
| res_valid | input | 1 | One-cycle completion strobe for res_data |
| left_adj | input | 1 | 1 selects the left-aligned packing, 0 the right-aligned packing |
| rd_lo | input | 1 | Bus read strobe for the low byte |
| rd_hi | input | 1 | Bus read strobe for the high byte |
| flag_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| data_lo | output | 8 | Low byte |
| data_hi | output | 8 | High byte |
| irq_flag | output | 1 | Completion interrupt flag |
| lost | output | 1 | 1 in a cycle where a completing result is discarded |

## Verification
Two pairs of events can fall in the same cycle here: a completion and a lock change, and a completion and a flag clear. The random stimulus sets `res_valid`, `rd_lo`, `rd_hi` and `flag_clr` independently in every cycle, so all of these overlaps occur many times. Directed sequences also place each one deliberately: a completion on the unlocking high-byte read, one on the locking low-byte read, and one on a flag clear. A bench model decides whether each result must be kept or dropped and which way the flag must go. It then compares both bytes, the flag and `lost` with the outputs in every cycle.

// File: rtl/adcrl_pkg.sv
package adcrl_pkg;

    parameter int RES_W  = 10;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } byte_pair_t;

    typedef enum logic {
        ALIGN_RIGHT = 1'b0,
        ALIGN_LEFT  = 1'b1
    } align_e;

    // Packs a raw result into two bytes, aligned to the bottom or the top of the pair.
    function automatic byte_pair_t pack_result(input logic [RES_W-1:0] raw, input align_e mode);
        logic [2*BYTE_W-1:0] wide;
        wide = {{(2*BYTE_W-RES_W){1'b0}}, raw};
        if (mode == ALIGN_LEFT)
            wide = wide << (2*BYTE_W - RES_W);
        return byte_pair_t'(wide);
    endfunction

endpackage

// File: rtl/adcrl_lock.sv
module adcrl_lock (
    input  logic clk,
    input  logic rst,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic locked
);
    // A low-byte read takes priority, so the pair stays frozen for the access that follows.
    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (rd_lo)
            locked <= 1'b1;
        else if (rd_hi)
            locked <= 1'b0;
    end

    assert_lock_set_R5: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> locked);
    assert_unlock_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !rd_lo) |=> !locked);
    assert_hi_only_no_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (!locked && !rd_lo) |=> !locked);
endmodule

// File: rtl/adcrl_store.sv
module adcrl_store
    import adcrl_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] res_data,
    input  logic         res_valid,
    input  logic         locked,
    output logic [W-1:0] raw_q,
    output logic         lost
);
    logic take;

    assign take = res_valid && !locked;
    assign lost = res_valid && locked;

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= '0;
        else if (take)
            raw_q <= res_data;
    end

    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (locked && res_valid) |=> $stable(raw_q));
    assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (!locked && res_valid) |=> (raw_q == $past(res_data)));
endmodule

// File: rtl/adcrl_flag.sv
module adcrl_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_ev)
            flag <= 1'b1;
        else if (clr_ev)
            flag <= 1'b0;
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> flag);
    assert_flag_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_ev && !set_ev) |=> !flag);
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
    import adcrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_valid,
    input  logic              left_adj,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] data_lo,
    output logic [BYTE_W-1:0] data_hi,
    output logic              irq_flag,
    output logic              lost
);
    logic             locked;
    logic [RES_W-1:0] raw_q;
    byte_pair_t       view;
    align_e           mode;

    adcrl_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .locked (locked)
    );

    adcrl_store #(.W(RES_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .res_data  (res_data),
        .res_valid (res_valid),
        .locked    (locked),
        .raw_q     (raw_q),
        .lost      (lost)
    );

    adcrl_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (res_valid),
        .clr_ev (flag_clr),
        .flag   (irq_flag)
    );

    // Packing is applied on the output side, so a change of alignment shows in the same cycle.
    assign mode = left_adj ? ALIGN_LEFT : ALIGN_RIGHT;
    always_comb view = pack_result(raw_q, mode);

    assign data_lo = view.lo;
    assign data_hi = view.hi;

    assert_lost_only_when_locked_R5: assert property (@(posedge clk) disable iff (rst)
        lost |-> (res_valid && locked));
    assert_bytes_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (lost && $stable(left_adj)) |=> ($stable(data_lo) || $changed(left_adj)));
endmodule

// File: tb/adc_result_latch_tb.sv
module adc_result_latch_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] res_data;
    logic       res_valid, left_adj, rd_lo, rd_hi, flag_clr;
    logic [7:0] data_lo, data_hi;
    logic       irq_flag, lost;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [9:0] m_raw;
    logic       m_lock, m_flag;

    always #10 clk = ~clk;

    adc_result_latch u_dut (
        .clk(clk), .rst(rst), .res_data(res_data), .res_valid(res_valid),
        .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
        .data_lo(data_lo), .data_hi(data_hi), .irq_flag(irq_flag), .lost(lost)
    );

    function automatic logic [7:0] exp_lo(input logic [9:0] r, input logic la);
        return la ? {r[1:0], 6'b0} : r[7:0];
    endfunction
    function automatic logic [7:0] exp_hi(input logic [9:0] r, input logic la);
        return la ? r[9:2] : {6'b0, r[9:8]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Compares outputs against the model for the inputs now applied, then advances the model.
    task automatic step_check(input string tag);
        #1;
        chk({tag, " lo"}, {8'b0, data_lo}, {8'b0, exp_lo(m_raw, left_adj)});
        chk({tag, " hi"}, {8'b0, data_hi}, {8'b0, exp_hi(m_raw, left_adj)});
        chk("R8/R9 flag", {15'b0, irq_flag}, {15'b0, m_flag});
        chk("R5 lost", {15'b0, lost}, {15'b0, res_valid & m_lock});
        if (res_valid && !m_lock) m_raw = res_data;
        if (res_valid) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
        if (rd_lo) m_lock = 1'b1;
        else if (rd_hi) m_lock = 1'b0;
    endtask

    task automatic drive(input logic v, input logic [9:0] d, input logic la,
                         input logic lo, input logic hi, input logic fc, input string tag);
        @(negedge clk);
        res_valid = v; res_data = d; left_adj = la;
        rd_lo = lo; rd_hi = hi; flag_clr = fc;
        step_check(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual hung expected finish");
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; res_valid = 0; res_data = 0; left_adj = 0;
        rd_lo = 0; rd_hi = 0; flag_clr = 0;
        m_raw = 0; m_lock = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 reset lo", {8'b0, data_lo}, 16'h0);
        chk("R1 reset hi", {8'b0, data_hi}, 16'h0);
        chk("R1 reset flag", {15'b0, irq_flag}, 16'h0);

        // R2 right packing
        drive(1, 10'h2A5, 0, 0, 0, 0, "R2");
        drive(0, 0, 0, 0, 0, 0, "R2");
        // R3/R4 repack without new conversion
        drive(0, 0, 1, 0, 0, 0, "R4");
        drive(0, 0, 0, 0, 0, 0, "R4");
        drive(1, 10'h3C7, 1, 0, 0, 0, "R3");
        drive(0, 0, 1, 0, 0, 0, "R3");
        // R7 high read alone, then accept
        drive(0, 0, 1, 0, 1, 0, "R7");
        drive(1, 10'h155, 1, 0, 0, 0, "R7");
        drive(0, 0, 1, 0, 0, 0, "R7");
        // R9 clear, and set wins over clear
        drive(0, 0, 0, 0, 0, 1, "R9");
        drive(1, 10'h0F0, 0, 0, 0, 1, "R9");
        drive(0, 0, 0, 0, 0, 0, "R9");
        // R5 lock then lost completion, R8 flag still set
        drive(0, 0, 0, 0, 0, 1, "R5");
        drive(0, 0, 0, 1, 0, 0, "R5");
        drive(1, 10'h3FF, 0, 0, 0, 0, "R5");
        drive(0, 0, 0, 0, 0, 0, "R8");
        // R6 completion on the unlocking read is dropped, then accepted
        drive(1, 10'h111, 0, 0, 1, 0, "R6");
        drive(0, 0, 0, 0, 0, 0, "R6");
        drive(1, 10'h222, 0, 0, 0, 0, "R6");
        drive(0, 0, 0, 0, 0, 0, "R6");
        // R10 completion on the locking read accepted; both reads lock
        drive(1, 10'h099, 0, 1, 0, 0, "R10");
        drive(1, 10'h066, 0, 0, 0, 0, "R10");
        drive(0, 0, 0, 0, 1, 0, "R10");
        drive(0, 0, 0, 1, 1, 0, "R10");
        drive(1, 10'h3AA, 0, 0, 0, 0, "R10");
        drive(0, 0, 0, 0, 1, 0, "R10");

        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 100) < 35, 10'($urandom), ($urandom % 100) < 50,
                  ($urandom % 100) < 15, ($urandom % 100) < 15,
                  ($urandom % 100) < 10, ($urandom % 2) ? "R2/R3 rand" : "R5/R6 rand");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule